// File: doc/BRIEF.md
# SMBus Byte Engine with Slave Address Match

This block sits between a small host register port and the two open-drain wires of an SMBus segment. One 8-bit shift register carries every byte on the wire, most significant bit first. A 7-bit own-address register sets the address the engine answers to. The host sees a status word with an active-low busy flag and an addressed-as-slave flag. A bus watcher follows START and STOP conditions on the synchronized line levels.

When the first byte after a START matches the own address, the engine acknowledges it. If the R/W bit of that byte is 0, the engine receives bytes. After each received byte it acknowledges and holds SCL low until the host reads the data register. If the R/W bit is 1, the engine holds SCL low until the host loads a byte with output enabled, then shifts that byte out. It then follows the master's acknowledge. The engine only pulls a line low or releases it, and it reads back the level of both lines.

Top module: `smb_byte_engine`

## Requirements
- R1: Status bit 0 (register index 0) reads 1 after reset and while the bus is free. It reads 0 after a START (SDA falls while SCL is high) and 1 again after a STOP (SDA rises while SCL is high).
- R2: The own-address register (index 1) holds 7 bits in bits 6..0 and resets to 00h. Bit 7 reads 0 whatever is written.
- R3: Bits 7..1 of the first byte after a START are compared with the own address. Bit 0 (R/W) is not compared, so own address 55h matches both AAh and ABh.
- R4: Status bit 1 is set on an address match and cleared by the next START or STOP. A byte that does not match leaves it at 0, and the engine leaves SDA released for the acknowledge bit.
- R5: After a matching address byte, SDA is pulled low from the eighth SCL fall to the ninth SCL fall, so the master reads an ACK of 0.
- R6: Received bits enter the data register (index 2) MSB first, and the host reads the complete byte there.
- R7: After a received data byte, the engine pulls SDA low (ACK) and holds SCL low. Both start at the eighth SCL fall. SCL is released one clock after the host reads the data register.
- R8: After a matching address with R/W = 1, SCL is held low until the host writes the data register while control bit 0 (output enable, index 3) is 1. The byte is then driven MSB first and is valid while SCL is high.
- R9: A data-register write while output enable is 0 does not start transmission, and SCL stays held low.
- R10: Control bit 7 is a soft reset that keeps its value until the host writes 0. While it is 1, the engine releases both lines, clears the match flag and ignores bus traffic.
- R11: After reset, the data and control registers read 00h and both line drivers are released.
- R12: After a transmitted byte, a master ACK (SDA 0) makes the engine hold SCL for the next host byte. A NACK releases both lines until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 2 | Register index: 0 status, 1 own address, 2 data, 3 control |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational from index) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A line edge reaches the engine three clocks later: two synchronizer flops, then the edge flop. Status bits and the line drivers change on that same third clock. A host read or write acts on the drivers at the next clock edge. The bench master holds every bus phase for ten clocks and samples SDA in the middle of the SCL high phase. Host-side and driver checks are taken at least one full clock after the edge that causes them, so every sample falls well after the result is due and before the next bus event.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int unsigned SMB_DW  = 8;
    localparam int unsigned SMB_AW  = SMB_DW - 1;
    localparam int unsigned SMB_CW  = $clog2(SMB_DW + 1);
    localparam int unsigned SMB_HAW = 2;

    localparam logic [SMB_HAW-1:0] REG_STAT = 2'd0;
    localparam logic [SMB_HAW-1:0] REG_OWN  = 2'd1;
    localparam logic [SMB_HAW-1:0] REG_DATA = 2'd2;
    localparam logic [SMB_HAW-1:0] REG_CTRL = 2'd3;

    localparam int unsigned CTRL_OUTEN_BIT = 0;
    localparam int unsigned CTRL_SRST_BIT  = SMB_DW - 1;
    localparam logic [SMB_DW-1:0] CTRL_MASK =
        (SMB_DW'(1) << CTRL_SRST_BIT) | (SMB_DW'(1) << CTRL_OUTEN_BIT);

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_RX,
        S_RX_ACK,
        S_TX_WAIT,
        S_TX,
        S_TX_ACK,
        S_SKIP
    } smb_state_e;

    typedef struct packed {
        smb_state_e        st;
        logic [SMB_DW-1:0] shreg;
        logic [SMB_CW-1:0] bcnt;
        logic              aas;
        logic              mack;
        logic              scl_low;
        logic              sda_low;
    } smb_eng_t;

    typedef struct packed {
        logic [SMB_AW-1:0] own;
        logic [SMB_DW-1:0] ctrl;
    } smb_regs_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    localparam int unsigned DEPTH = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[DEPTH-2:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_d;
        end

        assign lvl[g]  = sh_q[STAGES-1];
        assign rise[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
        assign fall[g] = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
endmodule

// File: rtl/smb_bus_watch.sv
module smb_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic bus_free
);
    logic free_d, free_q;

    assign start_evt = scl_lvl & sda_fall;
    assign stop_evt  = scl_lvl & sda_rise;

    always_comb begin
        free_d = free_q;
        if (start_evt)     free_d = 1'b0;
        else if (stop_evt) free_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_q <= 1'b1;
        else        free_q <= free_d;
    end

    assign bus_free = free_q;
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [SMB_HAW-1:0] host_addr,
    input  logic [SMB_DW-1:0]  host_wdata,
    input  logic               bus_free,
    input  logic               aas,
    input  logic [SMB_DW-1:0]  shreg,
    output logic [SMB_DW-1:0]  host_rdata,
    output logic [SMB_AW-1:0]  own_addr,
    output logic               out_en,
    output logic               soft_rst,
    output logic               wr_data_evt,
    output logic               rd_data_evt
);
    smb_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (host_wr) begin
            unique case (host_addr)
                REG_OWN:  r_d.own  = host_wdata[SMB_AW-1:0];
                REG_CTRL: r_d.ctrl = host_wdata & CTRL_MASK;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (host_addr)
            REG_STAT: host_rdata = {{(SMB_DW-2){1'b0}}, aas, bus_free};
            REG_OWN:  host_rdata = {1'b0, r_q.own};
            REG_DATA: host_rdata = shreg;
            default:  host_rdata = r_q.ctrl;
        endcase
    end

    assign own_addr    = r_q.own;
    assign out_en      = r_q.ctrl[CTRL_OUTEN_BIT];
    assign soft_rst    = r_q.ctrl[CTRL_SRST_BIT];
    assign wr_data_evt = host_wr & (host_addr == REG_DATA);
    assign rd_data_evt = host_rd & (host_addr == REG_DATA);
endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [SMB_AW-1:0] own_addr,
    input  logic              out_en,
    input  logic              soft_rst,
    input  logic              wr_data_evt,
    input  logic              rd_data_evt,
    input  logic [SMB_DW-1:0] host_wdata,
    output logic [SMB_DW-1:0] shreg,
    output logic              aas,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              rx_hold,
    output logic              tx_wait
);
    localparam logic [SMB_CW-1:0] FULL = SMB_CW'(SMB_DW);
    localparam logic [SMB_CW-1:0] LAST = SMB_CW'(SMB_DW - 1);
    localparam logic [SMB_CW-1:0] ONE  = SMB_CW'(1);

    smb_eng_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (soft_rst || start_evt || stop_evt) begin
            r_d.st      = start_evt && !soft_rst ? S_ADDR : S_IDLE;
            r_d.aas     = 1'b0;
            r_d.scl_low = 1'b0;
            r_d.sda_low = 1'b0;
            r_d.bcnt    = '0;
        end else begin
            unique case (r_q.st)
                S_IDLE, S_SKIP: begin
                    if (wr_data_evt) r_d.shreg = host_wdata;
                end
                S_ADDR: begin
                    if (scl_rise) begin
                        r_d.shreg = {r_q.shreg[SMB_DW-2:0], sda_lvl};
                        r_d.bcnt  = r_q.bcnt + ONE;
                    end else if (scl_fall && r_q.bcnt == FULL) begin
                        if (r_q.shreg[SMB_DW-1:1] == own_addr) begin
                            r_d.aas     = 1'b1;
                            r_d.sda_low = 1'b1;
                            r_d.st      = S_ADDR_ACK;
                        end else begin
                            r_d.st = S_SKIP;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.sda_low = 1'b0;
                        r_d.bcnt    = '0;
                        if (r_q.shreg[0]) begin
                            r_d.st      = S_TX_WAIT;
                            r_d.scl_low = 1'b1;
                        end else begin
                            r_d.st = S_RX;
                        end
                    end
                end
                S_RX: begin
                    if (scl_rise) begin
                        r_d.shreg = {r_q.shreg[SMB_DW-2:0], sda_lvl};
                        r_d.bcnt  = r_q.bcnt + ONE;
                    end else if (scl_fall && r_q.bcnt == FULL) begin
                        r_d.sda_low = 1'b1;
                        r_d.scl_low = 1'b1;
                        r_d.st      = S_RX_ACK;
                    end
                end
                S_RX_ACK: begin
                    if (rd_data_evt) r_d.scl_low = 1'b0;
                    if (scl_fall && !r_q.scl_low) begin
                        r_d.sda_low = 1'b0;
                        r_d.bcnt    = '0;
                        r_d.st      = S_RX;
                    end
                end
                S_TX_WAIT: begin
                    if (wr_data_evt) begin
                        r_d.shreg = host_wdata;
                        if (out_en) begin
                            r_d.sda_low = ~host_wdata[SMB_DW-1];
                            r_d.scl_low = 1'b0;
                            r_d.bcnt    = '0;
                            r_d.st      = S_TX;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        r_d.bcnt = r_q.bcnt + ONE;
                        if (r_q.bcnt == LAST) begin
                            r_d.sda_low = 1'b0;
                            r_d.st      = S_TX_ACK;
                        end else begin
                            r_d.shreg   = {r_q.shreg[SMB_DW-2:0], 1'b0};
                            r_d.sda_low = ~r_q.shreg[SMB_DW-2];
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) r_d.mack = ~sda_lvl;
                    if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.st      = S_TX_WAIT;
                            r_d.scl_low = 1'b1;
                        end else begin
                            r_d.st = S_SKIP;
                        end
                    end
                end
                default: r_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign shreg   = r_q.shreg;
    assign aas     = r_q.aas;
    assign scl_oe  = r_q.scl_low;
    assign sda_oe  = r_q.sda_low;
    assign rx_hold = (r_q.st == S_RX_ACK) && r_q.scl_low;
    assign tx_wait = (r_q.st == S_TX_WAIT);
endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
    import smb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int unsigned LN_SCL = 0;
    localparam int unsigned LN_SDA = 1;

    logic [1:0]        ln_lvl, ln_rise, ln_fall;
    logic              start_evt, stop_evt, bus_free;
    logic              aas, out_en, soft_rst;
    logic              wr_data_evt, rd_data_evt;
    logic              rx_hold, tx_wait;
    logic [SMB_DW-1:0] shreg;
    logic [SMB_AW-1:0] own_addr;

    smb_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sda_i, scl_i}),
        .lvl  (ln_lvl),
        .rise (ln_rise),
        .fall (ln_fall)
    );

    smb_bus_watch u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (ln_lvl[LN_SCL]),
        .sda_rise (ln_rise[LN_SDA]),
        .sda_fall (ln_fall[LN_SDA]),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .bus_free (bus_free)
    );

    smb_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .bus_free   (bus_free),
        .aas        (aas),
        .shreg      (shreg),
        .host_rdata (host_rdata),
        .own_addr   (own_addr),
        .out_en     (out_en),
        .soft_rst   (soft_rst),
        .wr_data_evt(wr_data_evt),
        .rd_data_evt(rd_data_evt)
    );

    smb_byte_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (ln_rise[LN_SCL]),
        .scl_fall   (ln_fall[LN_SCL]),
        .sda_lvl    (ln_lvl[LN_SDA]),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .own_addr   (own_addr),
        .out_en     (out_en),
        .soft_rst   (soft_rst),
        .wr_data_evt(wr_data_evt),
        .rd_data_evt(rd_data_evt),
        .host_wdata (host_wdata),
        .shreg      (shreg),
        .aas        (aas),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .rx_hold    (rx_hold),
        .tx_wait    (tx_wait)
    );
endmodule

// File: rtl/smb_byte_engine_chk.sv
module smb_byte_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start_evt,
    input logic stop_evt,
    input logic bus_free,
    input logic aas,
    input logic scl_oe,
    input logic sda_oe,
    input logic soft_rst,
    input logic out_en,
    input logic rd_data_evt,
    input logic wr_data_evt,
    input logic rx_hold,
    input logic tx_wait
);
    logic quiet;
    assign quiet = !start_evt && !stop_evt && !soft_rst;

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !bus_free);

    p_stop_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> bus_free);

    p_match_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt || stop_evt) |=> !aas);

    p_rx_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_hold && rd_data_evt && quiet) |=> !scl_oe);

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wait && wr_data_evt && !out_en && quiet) |=> scl_oe);

    p_tx_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wait && wr_data_evt && out_en && quiet) |=> !scl_oe);

    p_soft_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!scl_oe && !sda_oe && !aas));
endmodule

bind smb_byte_engine smb_byte_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .bus_free   (bus_free),
    .aas        (aas),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .soft_rst   (soft_rst),
    .out_en     (out_en),
    .rd_data_evt(rd_data_evt),
    .wr_data_evt(wr_data_evt),
    .rx_hold    (rx_hold),
    .tx_wait    (tx_wait)
);

// File: tb/sim_smb_byte_engine.sv
`timescale 1ns/1ps
module sim_smb_byte_engine;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_oe, sda_oe;
    wire        scl_line = scl_m & ~scl_oe;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0, failures = 0;
    bit done = 0;

    typedef struct { string req; logic [7:0] v; } item_t;
    item_t      exp_q[$];
    logic [7:0] act_q[$];

    always #4 clk = ~clk;

    smb_byte_engine u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // scoreboard monitor: compares design results against queued expectations
    initial begin
        item_t e;
        logic [7:0] a;
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                e = exp_q.pop_front();
                a = act_q.pop_front();
                checks++;
                if (a !== e.v) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", e.req, a, e.v);
                end
            end
        end
    end

    task automatic expect_item(input string req, input logic [7:0] v);
        item_t e;
        e.req = req; e.v = v;
        exp_q.push_back(e);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic scl_high();
        scl_m = 1'b1;
        while (scl_line !== 1'b1) @(negedge clk);
        wait_h();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_h();
        scl_high();
        sda_m = 1'b0; wait_h();
        scl_m = 1'b0; wait_h();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_h();
        scl_high();
        sda_m = 1'b1; wait_h();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_h();
        scl_high();
        scl_m = 1'b0; wait_h();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_h();
        scl_m = 1'b1;
        while (scl_line !== 1'b1) @(negedge clk);
        repeat (H/2) @(negedge clk);
        b = sda_line;
        repeat (H - H/2) @(negedge clk);
        scl_m = 1'b0; wait_h();
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
    endtask

    initial begin
        logic [7:0] d;
        logic       b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11 / R1 / R2: reset state
        host_read(2'd0, d); chk("R1 status after reset", d, 8'h01);
        host_read(2'd1, d); chk("R2 own addr reset", d, 8'h00);
        host_read(2'd2, d); chk("R11 data reset", d, 8'h00);
        host_read(2'd3, d); chk("R11 ctrl reset", d, 8'h00);
        chk("R11 drivers released", {6'd0, scl_oe, sda_oe}, 8'h00);

        // R2: bit 7 of own address reads 0
        host_write(2'd1, 8'hFF);
        host_read(2'd1, d); chk("R2 own addr width", d, 8'h7F);
        host_write(2'd1, 8'h55);

        // R3 R4 R5: matching write address, ACK, busy
        bus_start();
        host_read(2'd0, d); chk("R1 busy after START", d, 8'h00);
        put_byte(8'hAA);
        expect_item("R5 address ACK", 8'h00);
        get_bit(b); act_q.push_back({7'd0, b});
        host_read(2'd0, d); chk("R3 R4 match flag set", d, 8'h02);

        // R6 R7: received byte, stretch, release on read
        put_byte(8'h96);
        wait_h();
        chk("R7 stretch and ack held", {6'd0, scl_oe, sda_oe}, 8'h03);
        expect_item("R6 received byte MSB first", 8'h96);
        host_read(2'd2, d); act_q.push_back(d);
        @(negedge clk);
        chk("R7 SCL released after read", {7'd0, scl_oe}, 8'h00);
        expect_item("R7 data byte ACK", 8'h00);
        get_bit(b); act_q.push_back({7'd0, b});

        // R4: repeated START clears match flag
        bus_start();
        host_read(2'd0, d); chk("R4 cleared by START", d, 8'h00);

        // R4 R3: non-matching address is not acknowledged
        put_byte(8'h12);
        expect_item("R4 no ACK on mismatch", 8'h01);
        get_bit(b); act_q.push_back({7'd0, b});
        host_read(2'd0, d); chk("R4 no match flag", d, 8'h00);
        bus_stop();
        host_read(2'd0, d); chk("R1 free after STOP", d, 8'h01);

        // R8 R9 R12: read address ABh, transmit
        bus_start();
        put_byte(8'hAB);
        expect_item("R3 R/W bit ignored in match", 8'h00);
        get_bit(b); act_q.push_back({7'd0, b});
        wait_h();
        chk("R8 SCL held for host byte", {7'd0, scl_oe}, 8'h01);
        host_write(2'd2, 8'hC3);
        repeat (4) @(negedge clk);
        chk("R9 no start without output enable", {7'd0, scl_oe}, 8'h01);
        host_write(2'd3, 8'h01);
        host_write(2'd2, 8'h5A);
        @(negedge clk);
        chk("R8 SCL released on load", {7'd0, scl_oe}, 8'h00);
        expect_item("R8 transmitted byte", 8'h5A);
        get_byte(d); act_q.push_back(d);
        put_bit(1'b0);
        chk("R12 ACK re-arms stretch", {7'd0, scl_oe}, 8'h01);
        host_write(2'd2, 8'h81);
        expect_item("R8 second transmitted byte", 8'h81);
        get_byte(d); act_q.push_back(d);
        put_bit(1'b1);
        chk("R12 NACK releases lines", {6'd0, scl_oe, sda_oe}, 8'h00);
        bus_stop();
        host_read(2'd0, d); chk("R4 cleared by STOP", d, 8'h01);

        // R10: soft reset persists and blocks the engine
        host_write(2'd3, 8'h80);
        repeat (20) @(negedge clk);
        host_read(2'd3, d); chk("R10 soft reset bit persists", d, 8'h80);
        bus_start();
        put_byte(8'hAA);
        expect_item("R10 no ACK in soft reset", 8'h01);
        get_bit(b); act_q.push_back({7'd0, b});
        host_read(2'd0, d); chk("R10 no match in soft reset", d, 8'h00);
        bus_stop();
        host_write(2'd3, 8'h00);
        host_read(2'd3, d); chk("R10 soft reset cleared by host", d, 8'h00);

        repeat (5) @(negedge clk);
        if (exp_q.size() != 0 || act_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard leftover actual=%0d expected=%0d", act_q.size(), exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule